// File: doc/BRIEF.md
# Serial interrupt frame encoder

This block is the peripheral side of a one-wire serial interrupt link. Sixteen ISA-style IRQ levels and four PCI interrupt lines (INTA to INTD) share one open-drain wire, and all timing follows the PCI clock. The host controller opens each cycle with a start frame. The encoder then steps through twenty indication slots and pulls the wire low in the slot of every asserted input. After the last slot the host sends a stop frame. The length of that stop frame sets the mode of the next cycle: in continuous mode the host starts every cycle itself, and in quiet mode the encoder may ask for a cycle when one of its inputs changes.

The encoder never drives the wire high on its own, except in the clock right after one of its own low pulses. At all other times a high level comes from the pull-up. The line is modelled as an output enable `line_oe` and a drive value `line_drv`, together with `line_in`, the level sensed on the wire.

State machine states: `ST_IDLE` (waiting for a start frame, or deciding to request one), `ST_REQ` (one low clock asking the host to start), `ST_SAMPLE`, `ST_RECOVER` and `ST_TURN` (the three clocks of each slot), and `ST_STOP` (measuring the stop frame). Transitions: IDLE→SAMPLE on a valid start; IDLE→REQ on a quiet-mode change; REQ→IDLE always; SAMPLE→RECOVER; RECOVER→TURN; TURN→SAMPLE when slots remain; TURN→STOP after the last slot; STOP→IDLE when the wire returns high.

Top module: `sirq_encoder`

## Requirements
- R1: After reset the encoder does not drive the wire (`line_oe`=0, `line_drv`=0) and is in continuous mode.
- R2: A low run on `line_in` of 4 to 8 clocks, followed by a high clock, is taken as a start frame. The first sample clock of slot 0 is the cycle after the clock edge at which the wire is first seen high again.
- R3: A low run shorter than 4 or longer than 8 clocks does not start a cycle. The encoder then drives nothing.
- R4: Each slot lasts 3 clocks (sample, recovery, turnaround). Slot s reports `isa_irq[s]` for s = 0 to 15 and `pci_int[s-16]` for s = 16 to 19 (INTA first).
- R5: In the sample clock the encoder drives low (`line_oe`=1, `line_drv`=0) exactly when the reported input is 1 (asserted), and it otherwise floats.
- R6: In the recovery clock the encoder drives high (`line_oe`=1, `line_drv`=1) only if it drove low in the sample clock just before. Otherwise it floats.
- R7: In the turnaround clock the encoder floats (`line_oe`=0).
- R8: All inputs are captured at the start frame. Changes during the cycle do not alter the reported slots.
- R9: A stop frame of 2 low clocks selects quiet mode, 3 low clocks selects continuous mode, and any other length leaves the mode unchanged.
- R10: In quiet mode, while the wire is idle high and the inputs differ from the last captured set, the encoder drives exactly one low clock. It makes no further request until the next start frame.
- R11: In continuous mode an input change never causes a request.
- R12: `line_drv` is 1 only while `line_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| isa_irq | input | N_ISA (16) | ISA IRQ levels, 1 = asserted |
| pci_int | input | N_PCI (4) | PCI interrupts INTA..INTD, 1 = asserted |
| line_in | input | 1 | Sensed level of the shared wire |
| line_oe | output | 1 | Wire drive enable |
| line_drv | output | 1 | Value driven while enabled |

## Verification
On every cycle, the assertions check the electrical discipline of the wire. A high drive occurs only with the enable set and only right after a low drive. A high drive is always followed by a float. A low drive never lasts two clocks. Only the bench scenarios can show what depends on timing and on the data itself: which start and stop lengths are accepted, the slot order and its alignment to the start frame, that the snapshot holds during a cycle, and that a quiet-mode request appears once and only in quiet mode.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SAMPLE,
        ST_RECOVER,
        ST_TURN,
        ST_STOP
    } sirq_state_t;

    typedef enum logic {
        MODE_CONT,
        MODE_QUIET
    } sirq_mode_t;

endpackage

// File: rtl/sirq_lowrun.sv
// Measures consecutive low clocks on the wire; flags the end of a run.
module sirq_lowrun #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic [CNT_W-1:0] run_len,
    output logic             run_end
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (line_in) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign run_len = cnt;
    assign run_end = line_in && (cnt != '0);

endmodule

// File: rtl/sirq_slot_ctr.sv
// Index of the indication slot currently on the wire.
module sirq_slot_ctr #(
    parameter int N_SLOTS = 20,
    parameter int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(N_SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (clr) begin
            slot <= '0;
        end else if (adv) begin
            slot <= slot + 1'b1;
        end
    end

    assign last = (slot == LAST_IDX);

endmodule

// File: rtl/sirq_snapshot.sv
// Captures the interrupt inputs at a start frame; selects the bit for the
// current slot and flags any difference between live inputs and capture.
module sirq_snapshot #(
    parameter int N_ISA = 16,
    parameter int N_PCI = 4,
    parameter int N_SLOTS = N_ISA + N_PCI,
    parameter int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_ISA-1:0]  isa_irq,
    input  logic [N_PCI-1:0]  pci_int,
    input  logic [SLOT_W-1:0] slot,
    output logic              cur_bit,
    output logic              changed
);
    localparam int PAD_W = 2 ** SLOT_W;

    logic [N_SLOTS-1:0] live;
    logic [N_SLOTS-1:0] snap;
    logic [PAD_W-1:0]   padded;

    assign live = {pci_int, isa_irq};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (load) begin
            snap <= live;
        end
    end

    always_comb begin
        padded = '0;
        padded[N_SLOTS-1:0] = snap;
    end

    assign cur_bit = padded[slot];
    assign changed = (live != snap);

endmodule

// File: rtl/sirq_encoder.sv
module sirq_encoder #(
    parameter int N_ISA      = 16,
    parameter int N_PCI      = 4,
    parameter int START_MIN  = 4,
    parameter int START_MAX  = 8,
    parameter int STOP_QUIET = 2,
    parameter int STOP_CONT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ISA-1:0] isa_irq,
    input  logic [N_PCI-1:0] pci_int,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_drv
);
    import sirq_pkg::*;

    localparam int N_SLOTS = N_ISA + N_PCI;
    localparam int SLOT_W  = $clog2(N_SLOTS);
    localparam int CNT_W   = $clog2(START_MAX + 2);

    sirq_state_t state, state_nxt;
    sirq_mode_t  mode, mode_nxt;
    logic        req_sent, req_sent_nxt;

    logic [CNT_W-1:0]  run_len;
    logic              run_end;
    logic [SLOT_W-1:0] slot;
    logic              slot_last;
    logic              slot_clr, slot_adv;
    logic              cur_bit, changed;
    logic              start_ok;

    sirq_lowrun #(.CNT_W(CNT_W)) u_lowrun (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .run_len (run_len),
        .run_end (run_end)
    );

    sirq_slot_ctr #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (slot_clr),
        .adv   (slot_adv),
        .slot  (slot),
        .last  (slot_last)
    );

    sirq_snapshot #(.N_ISA(N_ISA), .N_PCI(N_PCI), .N_SLOTS(N_SLOTS),
                    .SLOT_W(SLOT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slot_clr),
        .isa_irq (isa_irq),
        .pci_int (pci_int),
        .slot    (slot),
        .cur_bit (cur_bit),
        .changed (changed)
    );

    // Start frame window check (R2, R3)
    assign start_ok = run_end
                   && (run_len >= CNT_W'(START_MIN))
                   && (run_len <= CNT_W'(START_MAX));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode     <= MODE_CONT;
            req_sent <= 1'b0;
        end else begin
            state    <= state_nxt;
            mode     <= mode_nxt;
            req_sent <= req_sent_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt    = state;
        mode_nxt     = mode;
        req_sent_nxt = req_sent;
        slot_clr     = 1'b0;
        slot_adv     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    state_nxt    = ST_SAMPLE;
                    slot_clr     = 1'b1;
                    req_sent_nxt = 1'b0;
                end else if (mode == MODE_QUIET && line_in && run_len == '0
                             && changed && !req_sent) begin
                    state_nxt = ST_REQ;
                end
            end
            ST_REQ: begin
                state_nxt    = ST_IDLE;
                req_sent_nxt = 1'b1;
            end
            ST_SAMPLE:  state_nxt = ST_RECOVER;
            ST_RECOVER: state_nxt = ST_TURN;
            ST_TURN: begin
                if (slot_last) begin
                    state_nxt = ST_STOP;
                end else begin
                    state_nxt = ST_SAMPLE;
                    slot_adv  = 1'b1;
                end
            end
            ST_STOP: begin
                if (run_end) begin
                    state_nxt = ST_IDLE;
                    if (run_len == CNT_W'(STOP_QUIET)) begin
                        mode_nxt = MODE_QUIET;
                    end else if (run_len == CNT_W'(STOP_CONT)) begin
                        mode_nxt = MODE_CONT;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        line_oe  = 1'b0;
        line_drv = 1'b0;
        unique case (state)
            ST_REQ:     line_oe = 1'b1;
            ST_SAMPLE:  line_oe = cur_bit;
            ST_RECOVER: begin
                line_oe  = cur_bit;
                line_drv = cur_bit;
            end
            default: begin
                line_oe  = 1'b0;
                line_drv = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sirq_encoder_chk.sv
module sirq_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic line_oe,
    input logic line_drv
);
    // R12: a high value is only ever presented while driving
    assert_drv_needs_oe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_drv |-> line_oe);

    // R6: a high drive follows a low drive of our own
    assert_high_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_drv) |-> $past(line_oe && !line_drv));

    // R7: the clock after a high drive is a float
    assert_float_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_drv) |=> !line_oe);

    // R5: a low drive lasts a single clock
    assert_low_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_drv) |=> !(line_oe && !line_drv));

endmodule

bind sirq_encoder sirq_encoder_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_oe  (line_oe),
    .line_drv (line_drv)
);

// File: tb/test_sirq_encoder.sv
`timescale 1ns/1ps
module test_sirq_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] isa_irq = '0;
    logic [3:0]  pci_int = '0;
    logic        host_low = 1'b0;
    logic        line_in;
    logic        line_oe, line_drv;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    // Open-drain wire: host pulls low, encoder drives, otherwise pull-up
    assign line_in = host_low ? 1'b0 : (line_oe ? line_drv : 1'b1);

    sirq_encoder i_sirq_encoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .isa_irq  (isa_irq),
        .pci_int  (pci_int),
        .line_in  (line_in),
        .line_oe  (line_oe),
        .line_drv (line_drv)
    );

    // {value[19:0], start length, stop length}
    localparam logic [27:0] VECS [0:5] = '{
        {20'hFFFFF, 4'd4, 4'd3},
        {20'h00000, 4'd8, 4'd3},
        {20'hA5A5A, 4'd5, 4'd3},
        {20'h5A5A5, 4'd6, 4'd3},
        {20'h80001, 4'd7, 4'd3},
        {20'h7FFFE, 4'd4, 4'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; runs one full cycle and checks every slot
    task automatic packet(input logic [19:0] v, input int slen, input int plen,
                          input bit flip, input string tag);
        {pci_int, isa_irq} = v;
        host_low = 1'b1;
        repeat (slen) @(negedge clk);
        host_low = 1'b0;
        @(negedge clk);
        if (flip) {pci_int, isa_irq} = ~v;
        for (int s = 0; s < 20; s++) begin
            chk(line_oe == v[s] && line_drv == 1'b0, {tag, " R4/R5 sample"},
                {line_oe, line_drv}, {v[s], 1'b0});
            @(negedge clk);
            chk(line_oe == v[s] && line_drv == v[s], {tag, " R6 recovery"},
                {line_oe, line_drv}, {v[s], v[s]});
            @(negedge clk);
            chk(line_oe == 1'b0, {tag, " R7 turnaround"}, line_oe, 0);
            @(negedge clk);
        end
        host_low = 1'b1;
        repeat (plen) @(negedge clk);
        host_low = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch(input int n, output int lows, output int drives);
        lows = 0;
        drives = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (line_oe) drives++;
            if (line_oe && !line_drv) lows++;
        end
    endtask

    initial begin
        #200us;
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lows, drives;
        repeat (3) @(negedge clk);
        chk(line_oe == 1'b0 && line_drv == 1'b0, "R1 reset drive", line_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_oe == 1'b0, "R1 after reset", line_oe, 0);

        // R11 / R1: continuous after reset, change makes no request
        {pci_int, isa_irq} = 20'h00F00;
        watch(6, lows, drives);
        chk(drives == 0, "R11 R1 no request in continuous", drives, 0);

        // R3: too short and too long start runs
        host_low = 1'b1;
        repeat (3) @(negedge clk);
        host_low = 1'b0;
        watch(8, lows, drives);
        chk(drives == 0, "R3 short start ignored", drives, 0);
        host_low = 1'b1;
        repeat (9) @(negedge clk);
        host_low = 1'b0;
        watch(8, lows, drives);
        chk(drives == 0, "R3 long start ignored", drives, 0);

        // R2: table of packets with varied start lengths
        for (int k = 0; k < 6; k++) begin
            packet(VECS[k][27:8], int'(VECS[k][7:4]), int'(VECS[k][3:0]), 1'b0, "R2");
        end

        // R8: inputs flipped after start must not alter the slots
        packet(20'h0F0F3, 5, 3, 1'b1, "R8");

        // R9 / R10: stop of 2 enters quiet mode
        packet(20'h00010, 4, 2, 1'b0, "R9");
        {pci_int, isa_irq} = 20'h00011;
        watch(8, lows, drives);
        chk(lows == 1 && drives == 1, "R10 quiet request single low", lows, 1);

        // R9: stop of 4 leaves quiet mode in place
        packet(20'h00011, 4, 4, 1'b0, "R9");
        {pci_int, isa_irq} = 20'h20000;
        watch(8, lows, drives);
        chk(lows == 1, "R9 odd stop keeps quiet", lows, 1);

        // R9: stop of 3 returns to continuous
        packet(20'h20000, 6, 3, 1'b0, "R9");
        {pci_int, isa_irq} = 20'h00002;
        watch(8, lows, drives);
        chk(drives == 0, "R9 stop 3 continuous no request", drives, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule